// File: doc/BRIEF.md
# Timer Interrupt Flag Aggregator

This block collects "count reached its reference" pulses from a set of timer channels and one watchdog. It keeps them in a single status word that software can read. Each source owns two sticky flags. A raw flag records every reference match. A request flag records only the matches that happened while that source's interrupt enable was high. All request flags are OR-ed together and gated by one global timer interrupt enable to form a single interrupt line.

Software reads the status word to find out which source fired. It then acknowledges by writing ones to the bits it wants cleared. Zero bits in a write leave their flags alone, so each flag can be cleared on its own without a read-modify-write race. The number of timer channels, the register width and the way the interrupt output is timed are all parameters.

Top module: `tmr_irq_agg`

## Requirements
- R1: While reset is asserted and right after it is released, the status word reads 0 and the interrupt output is 0.
- R2: An event pulse on timer n sets status bit 8+n at the next clock edge, whatever that timer's interrupt enable is.
- R3: The watchdog is the highest source index. Its event sets status bit 14. If its enable is 1 during the event, it also sets status bit 6.
- R4: Status bit n (timer n request) is set at the next edge only when timer n's event and its interrupt enable are both 1 in the same cycle.
- R5: Status bits 15 and 7 always read 0, including after a write of ones to them.
- R6: A write with wr_en_i high clears every flag whose bit is 1 in the write data. Flags whose write bit is 0 keep their value.
- R7: If an event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R8: A flag keeps its value on every edge where neither its event nor its clear arrives.
- R9: Raising a source's interrupt enable while its raw flag is already set does not set its request flag.
- R10: With the default combinational output mode, irq_o is 1 exactly when the global enable is 1 and at least one request flag is set. It follows the global enable within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Reference-reached pulses: timers 0..5, watchdog at index 6 |
| ien_i | input | 7 | Per-source interrupt enables, same indexing as evt_i |
| gie_i | input | 1 | Global timer interrupt enable |
| wr_en_i | input | 1 | Write strobe for the clear port |
| wr_data_i | input | 16 | Write-one-to-clear mask, laid out like the status word |
| rd_data_o | output | 16 | Status word: requests in the low half, raw flags in the high half |
| irq_o | output | 1 | Aggregated timer interrupt |

## Verification
The bench builds the block with its defaults: six timers plus the watchdog, a 16-bit word and the combinational interrupt mode. That lines up every source's raw and request bit with the fixed positions software decodes, including the reserved top bit of each half. It also puts the same-cycle response of irq_o to the global enable within reach. With these values the bench can walk every source through set, hold and clear. It can also hit the event-versus-clear collision on a real bit and write ones to the reserved bits.

// File: rtl/tia_pkg.sv
package tia_pkg;

   // How the aggregated interrupt line is produced
   typedef enum logic {
      TIA_IRQ_COMB = 1'b0,   // same-cycle function of flags and global enable
      TIA_IRQ_FLOP = 1'b1    // registered, one cycle later
   } tia_irq_mode_e;

   localparam int unsigned TIA_DEF_TIMERS = 6;
   localparam int unsigned TIA_DEF_REG_W  = 16;

endpackage

// File: rtl/tia_flag_bank.sv
module tia_flag_bank #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("tia_flag_bank: WIDTH must be at least 1");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q_o[g] <= 1'b0;
         else if (set_i[g])
            q_o[g] <= 1'b1;
         else if (clr_i[g])
            q_o[g] <= 1'b0;
      end

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> q_o[g]);

      // R6
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !set_i[g]) |=> !q_o[g]);

      // R8
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[g] && !set_i[g]) |=> $stable(q_o[g]));
   end

endmodule

// File: rtl/tia_irq_gate.sv
module tia_irq_gate #(
   parameter tia_pkg::tia_irq_mode_e MODE  = tia_pkg::TIA_IRQ_COMB,
   parameter int unsigned            WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] req_i,
   input  logic             gie_i,
   output logic             irq_o
);

   logic any_req;
   assign any_req = |req_i;

   if (MODE == tia_pkg::TIA_IRQ_FLOP) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= gie_i & any_req;
      end

      // R10
      irq_flop_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> $past(gie_i));
   end else begin : g_comb
      assign irq_o = gie_i & any_req;

      // R10
      irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> gie_i);

      // R10
      irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (req_i != '0));
   end

endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg #(
   parameter int unsigned            NUM_TMR  = tia_pkg::TIA_DEF_TIMERS,
   parameter int unsigned            REG_W    = tia_pkg::TIA_DEF_REG_W,
   parameter tia_pkg::tia_irq_mode_e IRQ_MODE = tia_pkg::TIA_IRQ_COMB,
   localparam int unsigned           NSRC     = NUM_TMR + 1,
   localparam int unsigned           HALF     = REG_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  evt_i,
   input  logic [NSRC-1:0]  ien_i,
   input  logic             gie_i,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             irq_o
);

   // Elaboration-time parameter checks
   if (REG_W % 2 != 0) begin : g_bad_odd
      $error("tmr_irq_agg: REG_W must be even");
   end
   if (NSRC + 1 > HALF) begin : g_bad_fit
      $error("tmr_irq_agg: each half needs NUM_TMR+1 flags plus a reserved top bit");
   end

   logic [NSRC-1:0]  raw_q, req_q;
   logic [NSRC-1:0]  raw_clr, req_clr, req_set;
   logic [REG_W-1:0] unused_wr;

   assign req_set = evt_i & ien_i;

   for (genvar i = 0; i < NSRC; i++) begin : g_clr
      assign req_clr[i] = wr_en_i & wr_data_i[i];
      assign raw_clr[i] = wr_en_i & wr_data_i[HALF + i];
   end

   tia_flag_bank #(.WIDTH(NSRC)) u_raw_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_i),
      .clr_i (raw_clr),
      .q_o   (raw_q)
   );

   tia_flag_bank #(.WIDTH(NSRC)) u_req_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (req_set),
      .clr_i (req_clr),
      .q_o   (req_q)
   );

   tia_irq_gate #(.MODE(IRQ_MODE), .WIDTH(NSRC)) u_irq_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_q),
      .gie_i (gie_i),
      .irq_o (irq_o)
   );

   // Status word: request flags in the low half, raw flags in the high half
   for (genvar b = 0; b < REG_W; b++) begin : g_rd
      if (b < NSRC) begin : g_req
         assign rd_data_o[b] = req_q[b];
         assign unused_wr[b] = 1'b0;
      end else if (b >= HALF && b < HALF + NSRC) begin : g_raw
         assign rd_data_o[b] = raw_q[b - HALF];
         assign unused_wr[b] = 1'b0;
      end else begin : g_rsv
         assign rd_data_o[b] = 1'b0;
         assign unused_wr[b] = wr_data_i[b];
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_chk
      // R2
      raw_on_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[i] |=> rd_data_o[HALF + i]);

      // R4
      req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req_q[i]) |-> $past(evt_i[i] && ien_i[i]));

      // R9
      req_no_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!req_q[i] && !evt_i[i]) |=> !req_q[i]);
   end

   // R5
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data_o[REG_W-1] && !rd_data_o[HALF-1]);

endmodule

// File: tb/test_tmr_irq_agg.sv
module test_tmr_irq_agg;

   localparam int unsigned NSRC = 7;
   localparam int          WDOG_CYC = 5000;

   typedef struct {
      logic [15:0] rd;
      logic        irq;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  evt = '0, ien = '0;
   logic        gie = 1'b0, wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        irq;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   exp_t sb[$];
   logic [6:0] m_raw = '0, m_req = '0;

   always #2ns clk = ~clk;

   tmr_irq_agg i_tmr_irq_agg (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt),
      .ien_i     (ien),
      .gie_i     (gie),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   function automatic logic [15:0] pack(input logic [6:0] raw, input logic [6:0] req);
      return {1'b0, raw, 1'b0, req};
   endfunction

   // Driver: one clock of stimulus, expectation pushed into the scoreboard
   task automatic step(input logic [6:0] e, input logic [6:0] en, input logic g,
                       input logic w, input logic [15:0] wd, input string tag);
      exp_t x;
      @(negedge clk);
      evt = e; ien = en; gie = g; wr_en = w; wr_data = wd;
      m_raw = (m_raw & ~(w ? wd[14:8] : 7'h0)) | e;
      m_req = (m_req & ~(w ? wd[6:0] : 7'h0)) | (e & en);
      x.rd  = pack(m_raw, m_req);
      x.irq = g & (|m_req);
      x.tag = tag;
      sb.push_back(x);
   endtask

   // Monitor: compares one cycle after each driven edge, away from the edge
   always @(posedge clk) begin
      #1ns;
      if (sb.size() > 0) begin
         exp_t x;
         x = sb.pop_front();
         n_cmp++;
         if (rd_data !== x.rd || irq !== x.irq) begin
            n_bad++;
            $display("FAIL %s: got rd=%h irq=%b, expected rd=%h irq=%b",
                     x.tag, rd_data, irq, x.rd, x.irq);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state observed while reset is held
      repeat (3) @(negedge clk);
      n_cmp++;
      if (rd_data !== 16'h0 || irq !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 in reset: got rd=%h irq=%b, expected rd=0000 irq=0", rd_data, irq);
      end
      rst_n = 1'b1;
      step(7'h00, 7'h00, 1'b1, 1'b0, 16'h0, "R1 after release");

      // R2: raw flag only when enable is low
      step(7'h08, 7'h00, 1'b1, 1'b0, 16'h0, "R2 raw only timer3");
      // R4 + R10: enabled event sets request and raises irq
      step(7'h02, 7'h02, 1'b1, 1'b0, 16'h0, "R4 req timer1");
      // R10: global enable low masks irq in the same cycle; R8 hold
      step(7'h00, 7'h00, 1'b0, 1'b0, 16'h0, "R10 gie low");
      step(7'h00, 7'h00, 1'b0, 1'b0, 16'h0, "R8 hold");
      step(7'h00, 7'h00, 1'b1, 1'b0, 16'h0, "R10 gie high again");
      // R3: watchdog flags at bits 14 and 6
      step(7'h40, 7'h40, 1'b1, 1'b0, 16'h0, "R3 watchdog");
      // R9: late enable on timer3 does not create a request
      step(7'h00, 7'h08, 1'b1, 1'b0, 16'h0, "R9 late enable");
      step(7'h00, 7'h08, 1'b1, 1'b0, 16'h0, "R9 late enable hold");
      // R6: clear timer1 request only, then a zero write
      step(7'h00, 7'h00, 1'b1, 1'b1, 16'h0002, "R6 clear req1");
      step(7'h00, 7'h00, 1'b1, 1'b1, 16'h0000, "R6 zero write");
      // R7: event and clear on the same flags in the same cycle
      step(7'h01, 7'h01, 1'b1, 1'b1, 16'h0101, "R7 set beats clear");
      // R5: ones written to reserved bits; all sources fire
      step(7'h00, 7'h00, 1'b1, 1'b1, 16'h8080, "R5 reserved write");
      step(7'h7F, 7'h7F, 1'b1, 1'b0, 16'h0, "R5 all sources");
      step(7'h00, 7'h00, 1'b1, 1'b1, 16'hFFFF, "R6 clear all");
      // R2/R4 per timer walk
      for (int n = 0; n < 6; n++) begin
         step(7'(1 << n), 7'(1 << n), 1'b1, 1'b0, 16'h0, "R4 walk event");
         step(7'h00, 7'h00, 1'b1, 1'b0, 16'h0, "R8 walk hold");
         step(7'h00, 7'h00, 1'b1, 1'b1, 16'h7F7F, "R6 walk clear");
      end
      // R8: sticky over several idle cycles
      step(7'h20, 7'h00, 1'b1, 1'b0, 16'h0, "R2 timer5 raw");
      for (int k = 0; k < 4; k++)
         step(7'h00, 7'h00, 1'b1, 1'b0, 16'h0, "R8 idle");
      step(7'h00, 7'h00, 1'b0, 1'b0, 16'h0, "R8 final");
      @(posedge clk);
      #2ns;
      finish_run();
   end

endmodule